// File: doc/BRIEF.md
# Dual-Read Data Memory with Region Decode

This block is a 16-bit data memory subsystem fed by two address buses. Every address is sorted into one of three regions: a dual-port internal RAM at the bottom of the space, a small peripheral register window at the very top, and everything in between, which is sent to an external memory port. In any cycle the block serves two reads (one on each bus), one read, or one write. Writes arrive on bus A only, with a single write-data path. Bus B reads only.

Internal and peripheral reads return one cycle after the address, each bus with its own valid strobe. A read or write that falls in the external region raises an external request, which stays up until an acknowledge arrives. While that access is open the block reports itself busy and ignores new requests. If both buses target the external region in the same cycle, bus A is served first and bus B second. A write on bus A together with a read on bus B is an illegal combination: the block flags a conflict and performs neither access.

Top module: `dual_read_dmem`

## Requirements
- R1: Region decode. Address below RAM_WORDS selects the internal RAM. Address at or above 2^AW − PER_WORDS selects the peripheral window, at offset (address − (2^AW − PER_WORDS)). Every other address selects the external region.
- R2: An accepted internal read presents its data on the bus's rdata with the bus's valid high in the cycle after the address is sampled. The valid is high for exactly that one cycle.
- R3: The two buses read independently in the same cycle. When both read the same internal address, both receive the same word.
- R4: An accepted bus-A write to the internal region stores the word, and a later read returns it. A write never raises a valid strobe.
- R5: A bus-A write together with a bus-B read in the same cycle raises conflict_err for one cycle in the next cycle. It produces no valid, no RAM write, no peripheral read or write and no external request.
- R6: A peripheral read drives per_rd for that bus's lane (bit 0 = bus A, bit 1 = bus B) and the window offset on the lane's per_raddr in the same cycle. The lane's per_rdata appears on the bus one cycle later with valid.
- R7: A peripheral write drives per_we, per_waddr (the window offset) and per_wdata in the same cycle. No valid follows.
- R8: An external access raises ext_req in the next cycle, together with ext_addr and ext_we (and ext_wdata for a write). These stay stable until ext_ack. For a read, the bus's rdata equals the acknowledged ext_rdata, with valid, in the cycle after ext_ack.
- R9: If both buses read the external region in the same cycle, bus A's address is requested first. Bus B's request follows in the cycle after bus A's acknowledge.
- R10: While busy is high (an external access is open), new requests on either bus are ignored. They cause no valid, no conflict, no peripheral strobe and no RAM write.
- R11: During and right after reset, a_valid, b_valid, conflict_err, ext_req and busy are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_req | input | 1 | Bus A access request |
| a_we | input | 1 | Bus A write (1) or read (0) |
| a_addr | input | AW | Bus A address |
| wdata | input | DW | Write data for bus A writes |
| b_req | input | 1 | Bus B read request |
| b_addr | input | AW | Bus B address |
| a_rdata | output | DW | Bus A read result |
| a_valid | output | 1 | Bus A read result valid |
| b_rdata | output | DW | Bus B read result |
| b_valid | output | 1 | Bus B read result valid |
| conflict_err | output | 1 | Write and read were requested together |
| busy | output | 1 | External access open; requests ignored |
| per_rd | output | 2 | Peripheral read strobe per lane (0 = A, 1 = B) |
| per_raddr | output | 2×PAW | Peripheral read offset per lane |
| per_rdata | input | 2×DW | Peripheral read data per lane |
| per_we | output | 1 | Peripheral write strobe |
| per_waddr | output | PAW | Peripheral write offset |
| per_wdata | output | DW | Peripheral write data |
| ext_req | output | 1 | External access request |
| ext_we | output | 1 | External access is a write |
| ext_addr | output | AW | External address |
| ext_wdata | output | DW | External write data |
| ext_ack | input | 1 | External access done |
| ext_rdata | input | DW | External read data, valid with ext_ack |

## Verification
The bench builds the block with AW = 16 and DW = 16, but shrinks the RAM to 256 words and the peripheral window to 16 registers. This puts both region edges close together: 0x00FF against 0x0100, and 0xFFEF against 0xFFF0. Each edge can be checked from both sides in a few directed accesses. It also keeps the memory small, while the decode comparisons, offset arithmetic and two-bus sequencing of external requests keep the same form they have at the default sizes.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

   typedef enum logic [1:0] {
      RG_RAM = 2'd0,
      RG_PER = 2'd1,
      RG_EXT = 2'd2
   } region_e;

   localparam int unsigned NBUS = 2;

endpackage

// File: rtl/dmem_decode.sv
module dmem_decode
   import dmem_pkg::*;
#(
   parameter int unsigned AW        = 16,
   parameter int unsigned RAM_WORDS = 2048,
   parameter int unsigned PER_WORDS = 64,
   localparam int unsigned RAW      = $clog2(RAM_WORDS),
   localparam int unsigned PAW      = $clog2(PER_WORDS)
) (
   input  logic [AW-1:0]  addr,
   output region_e        region,
   output logic [RAW-1:0] ram_idx,
   output logic [PAW-1:0] per_idx
);

   localparam int unsigned TOPW = AW - PAW;

   logic in_ram;
   logic in_per;

   // window sits at the top: upper bits all ones
   assign in_per  = (addr[AW-1:PAW] == {TOPW{1'b1}});
   // RAM sits at the bottom: upper bits all zero
   generate
      if (RAW < AW) begin : g_ram_hi
         assign in_ram = (addr[AW-1:RAW] == '0);
      end else begin : g_ram_all
         assign in_ram = 1'b1;
      end
   endgenerate

   always_comb begin
      if (in_ram)      region = RG_RAM;
      else if (in_per) region = RG_PER;
      else             region = RG_EXT;
   end

   assign ram_idx = addr[RAW-1:0];
   assign per_idx = addr[PAW-1:0];

endmodule

// File: rtl/dmem_ram.sv
module dmem_ram #(
   parameter int unsigned DW    = 16,
   parameter int unsigned WORDS = 2048,
   localparam int unsigned RAW  = $clog2(WORDS)
) (
   input  logic                clk,
   input  logic                we,
   input  logic [RAW-1:0]      waddr,
   input  logic [DW-1:0]       wdata,
   input  logic [1:0]          re,
   input  logic [1:0][RAW-1:0] raddr,
   output logic [1:0][DW-1:0]  rdata
);

   logic [DW-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   generate
      for (genvar p = 0; p < 2; p++) begin : g_rport
         always_ff @(posedge clk) begin
            if (re[p]) rdata[p] <= mem[raddr[p]];
         end
      end
   endgenerate

endmodule

// File: rtl/dmem_extseq.sv
module dmem_extseq #(
   parameter int unsigned AW = 16,
   parameter int unsigned DW = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         launch,
   input  logic [1:0][AW-1:0] laddr,
   input  logic               lwe,
   input  logic [DW-1:0]      lwdata,
   input  logic               ext_ack,
   output logic               busy,
   output logic               ext_req,
   output logic               ext_we,
   output logic [AW-1:0]      ext_addr,
   output logic [DW-1:0]      ext_wdata,
   output logic [1:0]         rd_done
);

   logic [1:0]         pend_q;
   logic [1:0][AW-1:0] addr_q;
   logic               we_q;
   logic [DW-1:0]      wd_q;
   logic               cur;

   // bus A always goes first
   assign cur       = ~pend_q[0];
   assign ext_req   = |pend_q;
   assign busy      = |pend_q;
   assign ext_addr  = addr_q[cur];
   assign ext_we    = ~cur & we_q;
   assign ext_wdata = wd_q;

   assign rd_done[0] = ext_req & ext_ack & ~cur & ~we_q;
   assign rd_done[1] = ext_req & ext_ack &  cur;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         addr_q <= '0;
         we_q   <= 1'b0;
         wd_q   <= '0;
      end else begin
         if (ext_req && ext_ack) pend_q[cur] <= 1'b0;
         for (int i = 0; i < 2; i++) begin
            if (launch[i]) begin
               pend_q[i] <= 1'b1;
               addr_q[i] <= laddr[i];
            end
         end
         if (launch[0]) begin
            we_q <= lwe;
            wd_q <= lwdata;
         end
      end
   end

endmodule

// File: rtl/dual_read_dmem.sv
module dual_read_dmem
   import dmem_pkg::*;
#(
   parameter int unsigned AW        = 16,
   parameter int unsigned DW        = 16,
   parameter int unsigned RAM_WORDS = 2048,
   parameter int unsigned PER_WORDS = 64,
   localparam int unsigned RAW      = $clog2(RAM_WORDS),
   localparam int unsigned PAW      = $clog2(PER_WORDS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                a_req,
   input  logic                a_we,
   input  logic [AW-1:0]       a_addr,
   input  logic [DW-1:0]       wdata,
   input  logic                b_req,
   input  logic [AW-1:0]       b_addr,
   output logic [DW-1:0]       a_rdata,
   output logic                a_valid,
   output logic [DW-1:0]       b_rdata,
   output logic                b_valid,
   output logic                conflict_err,
   output logic                busy,
   output logic [1:0]          per_rd,
   output logic [1:0][PAW-1:0] per_raddr,
   input  logic [1:0][DW-1:0]  per_rdata,
   output logic                per_we,
   output logic [PAW-1:0]      per_waddr,
   output logic [DW-1:0]      per_wdata,
   output logic                ext_req,
   output logic                ext_we,
   output logic [AW-1:0]       ext_addr,
   output logic [DW-1:0]       ext_wdata,
   input  logic                ext_ack,
   input  logic [DW-1:0]       ext_rdata
);

   // elaboration-time parameter checks
   generate
      if (RAM_WORDS != (1 << RAW)) begin : g_bad_ram
         $error("RAM_WORDS must be a power of two");
      end
      if (PER_WORDS != (1 << PAW) || PAW < 1) begin : g_bad_per
         $error("PER_WORDS must be a power of two of at least 2");
      end
      if (RAW >= AW || PAW >= AW || (RAM_WORDS + PER_WORDS) > (1 << AW)) begin : g_bad_map
         $error("RAM and peripheral window must fit apart in the address space");
      end
      if (DW < 1) begin : g_bad_dw
         $error("DW must be positive");
      end
   endgenerate

   logic [1:0][AW-1:0]  addr;
   region_e             rg [2];
   logic [1:0][RAW-1:0] ridx;
   logic [1:0][PAW-1:0] pidx;

   assign addr[0] = a_addr;
   assign addr[1] = b_addr;

   generate
      for (genvar g = 0; g < 2; g++) begin : g_dec
         dmem_decode #(
            .AW        (AW),
            .RAM_WORDS (RAM_WORDS),
            .PER_WORDS (PER_WORDS)
         ) u_dec (
            .addr    (addr[g]),
            .region  (rg[g]),
            .ram_idx (ridx[g]),
            .per_idx (pidx[g])
         );
      end
   endgenerate

   // arbitration
   logic       busy_w;
   logic       clash;
   logic       go;
   logic       wr_a;
   logic [1:0] rd;
   logic [1:0] ram_re;
   logic [1:0] launch;
   logic [1:0] ext_done;

   assign clash = a_req & a_we & b_req;
   assign go    = ~busy_w & ~clash;
   assign wr_a  = go & a_req & a_we;
   assign rd[0] = go & a_req & ~a_we;
   assign rd[1] = go & b_req;

   generate
      for (genvar g = 0; g < 2; g++) begin : g_steer
         assign ram_re[g]    = rd[g] & (rg[g] == RG_RAM);
         assign per_rd[g]    = rd[g] & (rg[g] == RG_PER);
         assign per_raddr[g] = pidx[g];
      end
   endgenerate

   assign launch[0] = go & a_req & (rg[0] == RG_EXT);
   assign launch[1] = rd[1] & (rg[1] == RG_EXT);

   assign per_we    = wr_a & (rg[0] == RG_PER);
   assign per_waddr = pidx[0];
   assign per_wdata = wdata;

   // internal RAM
   logic [1:0][DW-1:0] ram_q;

   dmem_ram #(
      .DW    (DW),
      .WORDS (RAM_WORDS)
   ) u_ram (
      .clk   (clk),
      .we    (wr_a & (rg[0] == RG_RAM)),
      .waddr (ridx[0]),
      .wdata (wdata),
      .re    (ram_re),
      .raddr (ridx),
      .rdata (ram_q)
   );

   // external sequencing
   dmem_extseq #(
      .AW (AW),
      .DW (DW)
   ) u_ext (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch),
      .laddr     (addr),
      .lwe       (a_we),
      .lwdata    (wdata),
      .ext_ack   (ext_ack),
      .busy      (busy_w),
      .ext_req   (ext_req),
      .ext_we    (ext_we),
      .ext_addr  (ext_addr),
      .ext_wdata (ext_wdata),
      .rd_done   (ext_done)
   );

   assign busy = busy_w;

   // result registers and muxing
   logic [1:0]         vld_q;
   logic [1:0]         sel_ram_q;
   logic [1:0][DW-1:0] hold_q;
   logic [1:0][DW-1:0] res;

   generate
      for (genvar g = 0; g < 2; g++) begin : g_res
         logic local_rd;
         assign local_rd = rd[g] & (rg[g] != RG_EXT);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q[g]     <= 1'b0;
               sel_ram_q[g] <= 1'b0;
               hold_q[g]    <= '0;
            end else begin
               vld_q[g] <= local_rd | ext_done[g];
               if (local_rd) sel_ram_q[g] <= (rg[g] == RG_RAM);
               if (per_rd[g]) hold_q[g] <= per_rdata[g];
               if (ext_done[g]) begin
                  hold_q[g]    <= ext_rdata;
                  sel_ram_q[g] <= 1'b0;
               end
            end
         end

         assign res[g] = sel_ram_q[g] ? ram_q[g] : hold_q[g];
      end
   endgenerate

   assign a_rdata = res[0];
   assign b_rdata = res[1];
   assign a_valid = vld_q[0];
   assign b_valid = vld_q[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) conflict_err <= 1'b0;
      else        conflict_err <= ~busy_w & clash;
   end

endmodule

// File: rtl/dual_read_dmem_chk.sv
module dual_read_dmem_chk #(
   parameter int unsigned AW        = 16,
   parameter int unsigned DW        = 16,
   parameter int unsigned RAM_WORDS = 2048,
   parameter int unsigned PER_WORDS = 64,
   localparam int unsigned PAW      = $clog2(PER_WORDS)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                a_req,
   input logic                a_we,
   input logic [AW-1:0]       a_addr,
   input logic                b_req,
   input logic [AW-1:0]       b_addr,
   input logic                a_valid,
   input logic                b_valid,
   input logic                conflict_err,
   input logic                busy,
   input logic [1:0]          per_rd,
   input logic                per_we,
   input logic                ext_req,
   input logic                ext_we,
   input logic [AW-1:0]       ext_addr,
   input logic                ext_ack
);

   a_r2_a_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (a_req && !a_we && !busy && a_addr < AW'(RAM_WORDS)) |=> a_valid);

   a_r2_b_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (b_req && !busy && !(a_req && a_we) && b_addr < AW'(RAM_WORDS)) |=> b_valid);

   a_r5_conflict_silent: assert property (@(posedge clk) disable iff (!rst_n)
      conflict_err |-> (!a_valid && !b_valid));

   a_r5_no_side_effects: assert property (@(posedge clk) disable iff (!rst_n)
      (a_req && a_we && b_req) |-> (!per_we && per_rd == 2'b00));

   a_r8_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_req && !ext_ack) |=> (ext_req && $stable(ext_addr) && $stable(ext_we)));

   a_r8_valid_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_req && ext_ack && !ext_we) |=> (a_valid || b_valid));

   a_r10_busy_no_peripheral: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (per_rd == 2'b00 && !per_we));

   a_r10_busy_no_conflict: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !conflict_err);

endmodule

bind dual_read_dmem dual_read_dmem_chk #(
   .AW        (AW),
   .DW        (DW),
   .RAM_WORDS (RAM_WORDS),
   .PER_WORDS (PER_WORDS)
) u_chk (.*);

// File: tb/dual_read_dmem_test.sv
module dual_read_dmem_test;

   localparam int unsigned AW  = 16;
   localparam int unsigned DW  = 16;
   localparam int unsigned RW  = 256;
   localparam int unsigned PW  = 16;
   localparam int unsigned PAW = 4;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                a_req = 0, a_we = 0, b_req = 0;
   logic [AW-1:0]       a_addr = '0, b_addr = '0;
   logic [DW-1:0]       wdata = '0;
   logic [DW-1:0]       a_rdata, b_rdata;
   logic                a_valid, b_valid, conflict_err, busy;
   logic [1:0]          per_rd;
   logic [1:0][PAW-1:0] per_raddr;
   logic [1:0][DW-1:0]  per_rdata;
   logic                per_we;
   logic [PAW-1:0]      per_waddr;
   logic [DW-1:0]       per_wdata;
   logic                ext_req, ext_we;
   logic [AW-1:0]       ext_addr;
   logic [DW-1:0]       ext_wdata;
   logic                ext_ack = 1'b0;
   logic [DW-1:0]       ext_rdata = '0;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   // peripheral model: each lane returns 0xC000 | offset, lane B also sets bit 8
   assign per_rdata[0] = 16'hC000 | DW'(per_raddr[0]);
   assign per_rdata[1] = 16'hC100 | DW'(per_raddr[1]);

   dual_read_dmem #(
      .AW(AW), .DW(DW), .RAM_WORDS(RW), .PER_WORDS(PW)
   ) uut (
      .clk(clk), .rst_n(rst_n),
      .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .wdata(wdata),
      .b_req(b_req), .b_addr(b_addr),
      .a_rdata(a_rdata), .a_valid(a_valid), .b_rdata(b_rdata), .b_valid(b_valid),
      .conflict_err(conflict_err), .busy(busy),
      .per_rd(per_rd), .per_raddr(per_raddr), .per_rdata(per_rdata),
      .per_we(per_we), .per_waddr(per_waddr), .per_wdata(per_wdata),
      .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
      .ext_ack(ext_ack), .ext_rdata(ext_rdata)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      a_req = 0; a_we = 0; b_req = 0; ext_ack = 0;
   endtask

   task automatic wr(input logic [AW-1:0] ad, input logic [DW-1:0] d);
      a_req = 1; a_we = 1; a_addr = ad; wdata = d;
      cyc();
      idle();
   endtask

   task automatic t_reset();
      check("R11 a_valid", a_valid, 0);
      check("R11 b_valid", b_valid, 0);
      check("R11 conflict", conflict_err, 0);
      check("R11 ext_req", ext_req, 0);
      check("R11 busy", busy, 0);
   endtask

   task automatic t_write_read();
      wr(16'h0010, 16'h1111);
      check("R4 no valid on write", a_valid, 0);
      wr(16'h0020, 16'h2222);
      a_req = 1; a_addr = 16'h0010;
      cyc(); idle();
      check("R2 a_valid", a_valid, 1);
      check("R4 readback", a_rdata, 16'h1111);
      cyc();
      check("R2 valid one cycle", a_valid, 0);
   endtask

   task automatic t_dual_read();
      a_req = 1; a_addr = 16'h0010; b_req = 1; b_addr = 16'h0020;
      cyc(); idle();
      check("R3 a data", a_rdata, 16'h1111);
      check("R3 b data", b_rdata, 16'h2222);
      check("R3 both valid", {a_valid, b_valid}, 2'b11);
      a_req = 1; a_addr = 16'h0020; b_req = 1; b_addr = 16'h0020;
      cyc(); idle();
      check("R3 same addr a", a_rdata, 16'h2222);
      check("R3 same addr b", b_rdata, 16'h2222);
      // bus B alone
      b_req = 1; b_addr = 16'h0010;
      cyc(); idle();
      check("R2 b alone valid", {a_valid, b_valid}, 2'b01);
      check("R2 b alone data", b_rdata, 16'h1111);
   endtask

   task automatic t_boundary();
      wr(16'h00FF, 16'hBEEF);
      b_req = 1; b_addr = 16'h00FF;
      cyc(); idle();
      check("R1 top RAM word", b_rdata, 16'hBEEF);
      check("R1 top RAM no ext", ext_req, 0);
      a_req = 1; a_addr = 16'hFFF0;
      #1;
      check("R1 window base strobe", per_rd, 2'b01);
      check("R1 window base offset", per_raddr[0], 0);
      cyc(); idle();
      check("R1 window base data", a_rdata, 16'hC000);
   endtask

   task automatic t_conflict();
      a_req = 1; a_we = 1; a_addr = 16'h0010; wdata = 16'h9999;
      b_req = 1; b_addr = 16'hFFF2;
      #1;
      check("R5 no per strobe", {per_rd, per_we}, 3'b000);
      cyc(); idle();
      check("R5 conflict flag", conflict_err, 1);
      check("R5 no valid", {a_valid, b_valid}, 2'b00);
      check("R5 no ext", ext_req, 0);
      cyc();
      check("R5 flag one cycle", conflict_err, 0);
      a_req = 1; a_addr = 16'h0010;
      cyc(); idle();
      check("R5 RAM unchanged", a_rdata, 16'h1111);
   endtask

   task automatic t_peripheral();
      a_req = 1; a_addr = 16'hFFF3; b_req = 1; b_addr = 16'hFFFF;
      #1;
      check("R6 strobes", per_rd, 2'b11);
      check("R6 offsets", {per_raddr[1], per_raddr[0]}, 8'hF3);
      cyc(); idle();
      check("R6 a data", a_rdata, 16'hC003);
      check("R6 b data", b_rdata, 16'hC10F);
      check("R6 valids", {a_valid, b_valid}, 2'b11);
      a_req = 1; a_we = 1; a_addr = 16'hFFF7; wdata = 16'h5A5A;
      #1;
      check("R7 per_we", per_we, 1);
      check("R7 waddr", per_waddr, 4'h7);
      check("R7 wdata", per_wdata, 16'h5A5A);
      cyc(); idle();
      check("R7 no valid", a_valid, 0);
   endtask

   task automatic t_external_single();
      a_req = 1; a_addr = 16'h0100;
      cyc(); idle();
      check("R1 0x0100 external", ext_req, 1);
      check("R8 ext_addr", ext_addr, 16'h0100);
      check("R8 read", ext_we, 0);
      check("R8 no early valid", a_valid, 0);
      // requests while busy are ignored
      b_req = 1; b_addr = 16'h0020;
      a_req = 1; a_we = 1; a_addr = 16'h0010; wdata = 16'hDEAD;
      cyc(); idle();
      check("R10 busy", busy, 1);
      check("R10 ignored valid", {a_valid, b_valid, conflict_err}, 3'b000);
      check("R8 held", {ext_req, ext_addr}, {1'b1, 16'h0100});
      ext_ack = 1; ext_rdata = 16'h7E01;
      cyc(); idle();
      check("R8 a_valid after ack", a_valid, 1);
      check("R8 data", a_rdata, 16'h7E01);
      check("R8 released", {ext_req, busy}, 2'b00);
      a_req = 1; a_addr = 16'h0010;
      cyc(); idle();
      check("R10 RAM not written", a_rdata, 16'h1111);
   endtask

   task automatic t_external_both();
      a_req = 1; a_addr = 16'hFFEF; b_req = 1; b_addr = 16'h4000;
      cyc(); idle();
      check("R9 A first", ext_addr, 16'hFFEF);
      ext_ack = 1; ext_rdata = 16'hAAAA;
      cyc(); idle();
      check("R9 A result", {a_valid, b_valid}, 2'b10);
      check("R9 A data", a_rdata, 16'hAAAA);
      check("R9 B next", {ext_req, ext_addr}, {1'b1, 16'h4000});
      ext_ack = 1; ext_rdata = 16'hBBBB;
      cyc(); idle();
      check("R9 B result", {a_valid, b_valid}, 2'b01);
      check("R9 B data", b_rdata, 16'hBBBB);
      check("R9 done", ext_req, 0);
   endtask

   task automatic t_external_write();
      a_req = 1; a_we = 1; a_addr = 16'h8000; wdata = 16'h3C3C;
      cyc(); idle();
      check("R8 write req", {ext_req, ext_we}, 2'b11);
      check("R8 write data", ext_wdata, 16'h3C3C);
      ext_ack = 1;
      cyc(); idle();
      check("R8 write no valid", {a_valid, b_valid}, 2'b00);
      check("R8 write done", ext_req, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      cyc();
      rst_n = 1'b1;
      cyc();
      t_reset();
      t_write_read();
      t_dual_read();
      t_boundary();
      t_conflict();
      t_peripheral();
      t_external_single();
      t_external_both();
      t_external_write();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule